// File: doc/BRIEF.md
# Multi-Mode Serial Test Pattern Generator

This block emits a serial test stream, one bit per clock, for exercising a link and the checker at its far end. A 4-bit mode input picks the pattern. There are four pseudorandom lengths, two constant levels, a one-zero toggle, a long-run stress pattern, and a user word. The user word is loaded through a write strobe and sent repeatedly.

An enable input gates emission. While enable is low the pattern position is frozen.

A second write port sets an injection interval N. Every N-th emitted bit is inverted and flagged, and a wrapping counter reports how many bits have been corrupted. This lets a downstream error detector and its alarm thresholds be driven with a known error rate.

Top module: `tpg_top`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, bit_o, bit_vld_o and err_flag_o are 0 and err_cnt_o is 0.
- R2: On each clock edge with en_i high and no restart, one bit is emitted and bit_vld_o is 1. With en_i low, bit_vld_o is 0 and the pattern position is held, so emission later resumes at the next bit.
- R3: A restart is either an edge where mode_i differs from the mode applied on the previous edge, or an edge where user_wr_i is high. A restart emits no bit (bit_vld_o is 0 after it) and returns the selected pattern to its first bit. The pseudorandom register is reloaded with all ones.
- R4: Mode 0 is the 7-stage sequence x^7+x^6+1. The register s starts at all ones, the emitted bit is s[6], and the next register is {s[5:0], s[6]^s[5]}. The sequence repeats every 127 bits and holds 64 ones per period.
- R5: Mode 1 is x^15+x^14+1, built the same way (emits s[14], feedback s[14]^s[13]). It repeats every 32767 bits with 16384 ones per period.
- R6: Mode 2 is x^23+x^18+1 (emits s[22], feedback s[22]^s[17]). Mode 3 is x^31+x^28+1 (emits s[30], feedback s[30]^s[27]). Both start from all ones.
- R7: Mode 4 emits constant 1 and mode 5 emits constant 0. Codes 9 to 15 emit constant 0.
- R8: Mode 6 emits an alternating stream whose first bit after a restart is 1.
- R9: Mode 7 emits RUN_LEN ones followed by one zero, and repeats (period RUN_LEN+1, default RUN_LEN=8).
- R10: Mode 8 emits the USER_W-bit user word (default 32) MSB first, repeated without gaps. user_wr_i loads user_word_i.
- R11: With interval N nonzero, emitted bit number k·N after the interval write (k ≥ 1) is inverted, and err_flag_o is 1 alongside it. N=1 inverts every bit and N=0 inverts none.
- R12: err_cnt_o increases by one for every inverted bit, wrapping at CNT_W bits.
- R13: An interval write on an edge where an inversion was due cancels that inversion: the bit goes out clean, err_cnt_o is unchanged, and counting toward the new N starts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Emit one bit per clock while high |
| mode_i | input | 4 | Pattern select (codes in R4 to R10) |
| user_wr_i | input | 1 | Load user word, restarts pattern |
| user_word_i | input | USER_W | User word value |
| err_period_wr_i | input | 1 | Load injection interval |
| err_period_i | input | PERIOD_W | Injection interval N, 0 disables |
| bit_o | output | 1 | Serial output bit |
| bit_vld_o | output | 1 | bit_o was emitted on the last edge |
| err_flag_o | output | 1 | bit_o was inverted on purpose |
| err_cnt_o | output | CNT_W | Number of inverted bits |

## Verification
An interval rewrite and a due inversion can land on the same edge. The bench provokes this by writing interval 4, emitting exactly three bits, and then rewriting the interval to 3 on the very edge that would have inverted the fourth bit. That bit must come out clean with no flag and no change in err_cnt_o. The next inversion must then fall exactly three emitted bits later. A mode change coinciding with active enable is also exercised: that edge must emit nothing, and the new pattern must start from its first bit.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [3:0] {
    M_PRBS7  = 4'd0,
    M_PRBS15 = 4'd1,
    M_PRBS23 = 4'd2,
    M_PRBS31 = 4'd3,
    M_ONES   = 4'd4,
    M_ZEROS  = 4'd5,
    M_ALT    = 4'd6,
    M_RUN    = 4'd7,
    M_USER   = 4'd8
  } tpg_mode_e;

  localparam int LFSR_W = 31;
  localparam int NUM_POLY = 4;

  function automatic int prbs_len(input int sel);
    case (sel)
      0: return 7;
      1: return 15;
      2: return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int prbs_tap(input int sel);
    case (sel)
      0: return 6;
      1: return 14;
      2: return 18;
      default: return 28;
    endcase
  endfunction
endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr
  import tpg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       step_i,
  input  logic [1:0] sel_i,
  output logic       bit_o
);
  logic [LFSR_W-1:0]   s_q;
  logic [NUM_POLY-1:0] fb_v, out_v;
  logic [LFSR_W-1:0]   mask_v [NUM_POLY];

  for (genvar k = 0; k < NUM_POLY; k++) begin : g_poly
    localparam int L = prbs_len(k);
    localparam int T = prbs_tap(k);
    assign fb_v[k]   = s_q[L-1] ^ s_q[T-1];
    assign out_v[k]  = s_q[L-1];
    assign mask_v[k] = {{(LFSR_W-L){1'b0}}, {L{1'b1}}};
  end

  assign bit_o = out_v[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        s_q <= '1;
    else if (restart_i) s_q <= '1;
    else if (step_i)    s_q <= {s_q[LFSR_W-2:0], fb_v[sel_i]};
  end

  // active state bits of the selected polynomial never all zero
  assert_no_lockup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_q & mask_v[sel_i]) != '0);
endmodule

// File: rtl/tpg_fixed_pat.sv
module tpg_fixed_pat
  import tpg_pkg::*;
#(
  parameter int USER_W  = 32,
  parameter int RUN_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              step_i,
  input  tpg_mode_e         mode_i,
  input  logic              user_wr_i,
  input  logic [USER_W-1:0] user_word_i,
  output logic              bit_o
);
  localparam int IDX_W = $clog2(USER_W);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(USER_W - 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN);

  logic [USER_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic [RUN_W-1:0]  run_q;
  logic              alt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= '0;
      run_q  <= '0;
      alt_q  <= 1'b1;
    end else begin
      if (user_wr_i) word_q <= user_word_i;
      if (restart_i) begin
        idx_q <= '0;
        run_q <= '0;
        alt_q <= 1'b1;
      end else if (step_i) begin
        idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        run_q <= (run_q == RUN_LAST) ? '0 : run_q + 1'b1;
        alt_q <= ~alt_q;
      end
    end
  end

  always_comb begin
    unique case (mode_i)
      M_ONES:  bit_o = 1'b1;
      M_ALT:   bit_o = alt_q;
      M_RUN:   bit_o = (run_q != RUN_LAST);
      M_USER:  bit_o = word_q[IDX_LAST - idx_q];
      default: bit_o = 1'b0;
    endcase
  end

  assert_run_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_LAST);
  assert_idx_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_LAST);
endmodule

// File: rtl/tpg_err_inj.sv
module tpg_err_inj #(
  parameter int PERIOD_W = 16,
  parameter int CNT_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                period_wr_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                emit_i,
  output logic                inject_o,
  output logic [CNT_W-1:0]    err_cnt_o
);
  logic [PERIOD_W-1:0] period_q, icnt_q;

  assign inject_o = emit_i && !period_wr_i && (period_q != '0) &&
                    (icnt_q == period_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q  <= '0;
      icnt_q    <= '0;
      err_cnt_o <= '0;
    end else begin
      if (period_wr_i) begin
        period_q <= period_i;
        icnt_q   <= '0;
      end else if (emit_i && period_q != '0) begin
        icnt_q <= inject_o ? '0 : icnt_q + 1'b1;
      end
      if (inject_o) err_cnt_o <= err_cnt_o + 1'b1;
    end
  end

  assert_off_when_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_q == '0 |-> !inject_o);
  assert_icnt_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_q != '0 |-> icnt_q < period_q);
  assert_cnt_step_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_o |=> err_cnt_o == $past(err_cnt_o) + 1'b1);
  assert_wr_clear_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_wr_i |=> icnt_q == '0);
endmodule

// File: rtl/tpg_top.sv
module tpg_top
  import tpg_pkg::*;
#(
  parameter int USER_W   = 32,
  parameter int RUN_LEN  = 8,
  parameter int PERIOD_W = 16,
  parameter int CNT_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [3:0]          mode_i,
  input  logic                user_wr_i,
  input  logic [USER_W-1:0]   user_word_i,
  input  logic                err_period_wr_i,
  input  logic [PERIOD_W-1:0] err_period_i,
  output logic                bit_o,
  output logic                bit_vld_o,
  output logic                err_flag_o,
  output logic [CNT_W-1:0]    err_cnt_o
);
  tpg_mode_e mode_q, mode_in;
  logic restart, emit, inject, prbs_bit, fix_bit, raw_bit, is_prbs;

  assign mode_in = tpg_mode_e'(mode_i);
  assign restart = (mode_in != mode_q) || user_wr_i;
  assign emit    = en_i && !restart;
  assign is_prbs = (mode_q == M_PRBS7) || (mode_q == M_PRBS15) ||
                   (mode_q == M_PRBS23) || (mode_q == M_PRBS31);
  assign raw_bit = is_prbs ? prbs_bit : fix_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= M_PRBS7;
      bit_o      <= 1'b0;
      bit_vld_o  <= 1'b0;
      err_flag_o <= 1'b0;
    end else begin
      mode_q     <= mode_in;
      bit_vld_o  <= emit;
      err_flag_o <= inject;
      if (emit) bit_o <= raw_bit ^ inject;
    end
  end

  tpg_lfsr u_lfsr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .step_i    (emit && is_prbs),
    .sel_i     (mode_q[1:0]),
    .bit_o     (prbs_bit)
  );

  tpg_fixed_pat #(.USER_W(USER_W), .RUN_LEN(RUN_LEN)) u_fixed (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart),
    .step_i      (emit),
    .mode_i      (mode_q),
    .user_wr_i   (user_wr_i),
    .user_word_i (user_word_i),
    .bit_o       (fix_bit)
  );

  tpg_err_inj #(.PERIOD_W(PERIOD_W), .CNT_W(CNT_W)) u_inj (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .period_wr_i (err_period_wr_i),
    .period_i    (err_period_i),
    .emit_i      (emit),
    .inject_o    (inject),
    .err_cnt_o   (err_cnt_o)
  );

  assert_restart_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !bit_vld_o);
  assert_flag_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flag_o |-> bit_vld_o);
  assert_ones_const_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o && mode_q == M_ONES && !err_flag_o |-> bit_o);
  assert_zeros_const_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o && mode_q == M_ZEROS && !err_flag_o |-> !bit_o);
  assert_alt_toggle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o && $past(bit_vld_o) && mode_q == M_ALT && $past(mode_q) == M_ALT &&
    !err_flag_o && !$past(err_flag_o) |-> bit_o != $past(bit_o));
endmodule

// File: tb/tb_tpg_top.sv
`timescale 1ns/1ps
module tb_tpg_top;
  localparam int USER_W = 32, RUN_LEN = 8, PERIOD_W = 16, CNT_W = 16;

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b0, user_wr = 1'b0, per_wr = 1'b0;
  logic [3:0] mode = 4'd0;
  logic [USER_W-1:0] word = '0;
  logic [PERIOD_W-1:0] per = '0;
  logic bit_o, vld, eflag;
  logic [CNT_W-1:0] ecnt;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  tpg_top #(.USER_W(USER_W), .RUN_LEN(RUN_LEN), .PERIOD_W(PERIOD_W), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .mode_i(mode), .user_wr_i(user_wr),
    .user_word_i(word), .err_period_wr_i(per_wr), .err_period_i(per),
    .bit_o(bit_o), .bit_vld_o(vld), .err_flag_o(eflag), .err_cnt_o(ecnt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic restart(input logic [3:0] m);
    en = 1'b0; mode = 4'd15; tick(); mode = m; tick();
  endtask

  task automatic load_word(input logic [USER_W-1:0] w);
    en = 1'b0; word = w; user_wr = 1'b1; tick(); user_wr = 1'b0;
  endtask

  task automatic wr_period(input logic [PERIOD_W-1:0] v);
    en = 1'b0; per = v; per_wr = 1'b1; tick(); per_wr = 1'b0;
  endtask

  function automatic logic fixed_exp(input logic [3:0] m, input int j, input logic [USER_W-1:0] w);
    case (m)
      4'd4: return 1'b1;
      4'd6: return (j % 2) == 0;
      4'd7: return (j % (RUN_LEN + 1)) != RUN_LEN;
      4'd8: return w[USER_W-1-(j % USER_W)];
      default: return 1'b0;
    endcase
  endfunction

  // emits n bits from a fresh pattern start and fresh interval count
  task automatic stream(input logic [3:0] m, input int n, input int nper,
                        input logic [USER_W-1:0] w, input string req);
    logic [30:0] s = '1;
    int len, tap, bad = 0;
    logic [31:0] fa = '0, fe = '0;
    logic [CNT_W-1:0] c0;
    len = (m == 0) ? 7 : (m == 1) ? 15 : (m == 2) ? 23 : 31;
    tap = (m == 0) ? 6 : (m == 1) ? 14 : (m == 2) ? 18 : 28;
    c0 = ecnt;
    en = 1'b1;
    for (int j = 0; j < n; j++) begin
      logic e, ei;
      if (m < 4) begin
        e = s[len-1];
        s = {s[29:0], s[len-1] ^ s[tap-1]};
      end else e = fixed_exp(m, j, w);
      ei = (nper != 0) && ((j + 1) % nper == 0);
      tick();
      if (bad == 0 && ({vld, eflag, bit_o} !== {1'b1, ei, e ^ ei})) begin
        bad = 1; fa = {vld, eflag, bit_o}; fe = {1'b1, ei, e ^ ei};
      end
    end
    en = 1'b0;
    chk(req, fa, fe);
    if (nper != 0) chk({req, " R12 count"}, ecnt - c0, CNT_W'(n / nper));
  endtask

  initial begin
    #(5.0 * 200000);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk("R1 reset outputs", {bit_o, vld, eflag}, 3'b000);
    chk("R1 reset count", ecnt, 0);
    repeat (3) tick();
    rst_ni = 1'b1; tick();
    chk("R1 after release", {bit_o, vld, eflag, 13'd0, ecnt}, 0);

    // R4: model match plus period and balance
    begin
      logic [253:0] cap;
      int ones = 0;
      restart(4'd0);
      stream(4'd0, 127, 0, '0, "R4 prbs7 sequence");
      restart(4'd0); en = 1'b1;
      for (int j = 0; j < 254; j++) begin tick(); cap[j] = bit_o; end
      en = 1'b0;
      for (int j = 0; j < 127; j++) ones += cap[j];
      chk("R4 prbs7 ones per period", ones, 64);
      chk("R4 prbs7 period", cap[253:127], cap[126:0]);
      chk("R4 prbs7 not period 63", (cap[62:0] == cap[125:63]), 0);
    end

    // R5: period 32767
    begin
      logic [63:0] head, tail;
      int ones = 0;
      restart(4'd1);
      stream(4'd1, 200, 0, '0, "R5 prbs15 sequence");
      restart(4'd1); en = 1'b1;
      for (int j = 0; j < 32767 + 64; j++) begin
        tick();
        if (j < 32767) ones += bit_o;
        if (j < 64) head[j] = bit_o;
        if (j >= 32767) tail[j-32767] = bit_o;
      end
      en = 1'b0;
      chk("R5 prbs15 ones per period", ones, 16384);
      chk("R5 prbs15 period low", tail[31:0], head[31:0]);
      chk("R5 prbs15 period high", tail[63:32], head[63:32]);
    end

    restart(4'd2); stream(4'd2, 300, 0, '0, "R6 prbs23 sequence");
    restart(4'd3); stream(4'd3, 300, 0, '0, "R6 prbs31 sequence");
    restart(4'd4); stream(4'd4, 40, 0, '0, "R7 all ones");
    restart(4'd5); stream(4'd5, 40, 0, '0, "R7 all zeros");
    restart(4'd12); stream(4'd12, 20, 0, '0, "R7 unused code zero");
    restart(4'd6); stream(4'd6, 41, 0, '0, "R8 alternating");
    restart(4'd7); stream(4'd7, 40, 0, '0, "R9 run length");
    restart(4'd8); load_word(32'hC35A_0F81); stream(4'd8, 96, 0, 32'hC35A_0F81, "R10 user word");

    // R2: hold during enable low
    begin
      logic [31:0] w = 32'hF0E1_D2C3;
      logic [9:0] got, exp;
      restart(4'd8); load_word(w); en = 1'b1;
      for (int j = 0; j < 5; j++) begin tick(); got[j] = bit_o; end
      en = 1'b0;
      tick(); chk("R2 no valid while disabled", vld, 0);
      tick(); tick();
      en = 1'b1;
      for (int j = 5; j < 10; j++) begin tick(); got[j] = bit_o; end
      en = 1'b0;
      for (int j = 0; j < 10; j++) exp[j] = w[31-j];
      chk("R2 resume after pause", got, exp);
    end

    // R3: mode change with enable held high
    restart(4'd0); en = 1'b1;
    repeat (5) tick();
    mode = 4'd6; tick();
    chk("R3 restart edge emits nothing", vld, 0);
    tick(); chk("R3 new pattern first bit", {vld, bit_o}, 2'b11);
    tick(); chk("R3 new pattern second bit", {vld, bit_o}, 2'b10);
    en = 1'b0;
    restart(4'd0); stream(4'd0, 20, 0, '0, "R3 prbs restarts from seed");

    // R11/R12 directed
    restart(4'd5); wr_period(16'd5); stream(4'd5, 23, 5, '0, "R11 period 5");
    restart(4'd4); wr_period(16'd1); stream(4'd4, 17, 1, '0, "R11 period 1");
    restart(4'd6); wr_period(16'd0); stream(4'd6, 30, 0, '0, "R11 period 0");
    chk("R12 no count when disabled", eflag, 0);

    // R13: interval write on the edge of a due inversion
    begin
      logic [CNT_W-1:0] c0;
      restart(4'd5); wr_period(16'd4);
      en = 1'b1; repeat (3) tick();
      c0 = ecnt;
      per = 16'd3; per_wr = 1'b1; tick(); per_wr = 1'b0;
      chk("R13 due bit goes clean", {vld, eflag, bit_o}, 3'b100);
      chk("R13 count unchanged", ecnt, c0);
      tick(); tick();
      chk("R13 no early inversion", eflag, 0);
      tick();
      chk("R13 inversion after new N", {vld, eflag, bit_o}, 3'b111);
      en = 1'b0; tick();
      chk("R13 count after new N", ecnt, c0 + 1'b1);
    end

    // random user words and modes with random intervals
    for (int r = 0; r < 8; r++) begin
      logic [31:0] w = $urandom;
      logic [3:0] m = 4'($urandom % 9);
      int nper = 2 + ($urandom % 7);
      restart(m);
      if (m == 4'd8) load_word(w);
      wr_period(PERIOD_W'(nper));
      stream(m, 60 + ($urandom % 40), nper, w, "R11 random inject");
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule